// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational adder for two unsigned operands and a carry-in. It returns the full sum and a carry-out. The word is cut into slices whose widths grow toward the most significant end. The lowest slice is a plain ripple adder driven by the external carry. Every other slice works out its local sum twice:

- once with a ripple adder that assumes no incoming carry;
- once by adding one to that result, including its local carry, through a gate-level increment converter that is one bit wider than the slice.

The real carry from the slice below then picks one of the two results. A single select line steers both the sum bits and the slice carry.

The slice widths come from the word width alone. The first two slices are 2 bits each. Each later slice is one bit wider than the one before it, and the topmost slice takes whatever bits remain. With this rule a 16-bit adder splits as 2,2,3,4,5. The same module is used at 8, 16, 32, 64 and 128 bits.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals a_in + b_in + carry_in, computed WIDTH+1 bits wide. This holds at widths 8, 16, 32, 64 and 128.
- R2: With the operands held fixed, raising carry_in from 0 to 1 raises the (WIDTH+1)-bit result by exactly one.
- R3: With all-ones operands, the outputs are sum_out all ones except bit 0 and carry_out=1 when carry_in=0. They are sum_out all ones and carry_out=1 when carry_in=1.
- R4: When a_in = 2^k-1, b_in = 0 and carry_in = 1, a carry ripples out of the low k bits. The result is sum_out = 2^k with carry_out = 0 for k < WIDTH, and sum_out = 0 with carry_out = 1 for k = WIDTH.
- R5: Each increment converter of n bits returns its input plus one modulo 2^n. It does this with inverters, AND and XOR gates only.
- R6: Each upper slice of width w yields {slice carry, slice sum} = a_slice + b_slice + sel, computed w+1 bits wide. Here sel is the carry out of the slice below.
- R7: The carry entering each slice equals the true carry into that bit position of the full addition. The carry leaving the lowest slice equals bit 2 of a_in[1:0] + b_in[1:0] + carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First addend |
| b_in | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The block has no state, so any internal fault shows at the ports at once, in the same evaluation as the input change.

- A stuck or wrongly wired select shows only when the slice below produces a carry. The sweeps therefore include runs of ones that end at every bit position, so that each slice boundary is crossed.
- A faulty converter bit shows only when its input has a run of low ones. That case is covered by the all-ones operands and by the exhaustive sweep at 8 bits.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Nominal slice width: 2,2,3,4,5,...
  function automatic int grp_nominal(input int g);
    return (g == 0) ? 2 : g + 1;
  endfunction

  // Number of slices needed to cover 'total' bits
  function automatic int grp_count(input int total);
    int acc;
    int n;
    acc = 0;
    n = 0;
    while (acc < total) begin
      acc += grp_nominal(n);
      n++;
    end
    return n;
  endfunction

  // Bit position of the least significant bit of slice g
  function automatic int grp_lsb(input int total, input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += grp_nominal(i);
    if (acc > total) acc = total;
    return acc;
  endfunction

  // Actual width of slice g; the topmost slice takes the remainder
  function automatic int grp_width(input int total, input int g);
    int lsb;
    int w;
    lsb = grp_lsb(total, g);
    w = grp_nominal(g);
    if (lsb + w > total) w = total - lsb;
    return w;
  endfunction

endpackage

// File: rtl/csa_rca.sv
module csa_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]       = a[i] ^ b[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
  end

  assign co = chain[W];

endmodule

// File: rtl/csa_exc1.sv
module csa_exc1 #(
  parameter int N = 5
) (
  input  logic [N-1:0] x,
  output logic [N-1:0] y
);

  // all_low[i] = x[0] & ... & x[i]
  logic [N-1:0] all_low;

  assign all_low[0] = x[0];
  assign y[0]       = ~x[0];

  for (genvar i = 1; i < N; i++) begin : g_bit
    assign all_low[i] = all_low[i-1] & x[i];
    assign y[i]       = x[i] ^ all_low[i-1];
  end

  always_comb begin
    if (!$isunknown(x)) begin
      a_r5_plus_one: assert (y == N'(x + N'(1)))
        else $error("R5 converter result wrong");
    end
  end

endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);

  localparam int XW = W + 1;

  logic [W-1:0]  zero_sum;
  logic          zero_carry;
  logic [XW-1:0] zero_res;
  logic [XW-1:0] inc_res;
  logic [XW-1:0] pick;

  csa_rca #(.W(W)) u_rca (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (zero_sum),
    .co (zero_carry)
  );

  assign zero_res = {zero_carry, zero_sum};

  csa_exc1 #(.N(XW)) u_inc (
    .x (zero_res),
    .y (inc_res)
  );

  assign pick = sel ? inc_res : zero_res;
  assign s    = pick[W-1:0];
  assign co   = pick[W];

  always_comb begin
    if (!$isunknown({a, b, sel})) begin
      a_r6_slice_sum: assert ({co, s} == (XW'(a) + XW'(b) + XW'(sel)))
        else $error("R6 slice result wrong");
    end
  end

endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csa_pkg::*;
#(
  parameter int WIDTH = 128
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  localparam int NGRP = grp_count(WIDTH);

  // Carry entering each slice; grp_carry[NGRP] leaves the top slice
  logic [NGRP:0] grp_carry;
  assign grp_carry[0] = carry_in;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    localparam int LSB = grp_lsb(WIDTH, g);
    localparam int GW  = grp_width(WIDTH, g);
    if (g == 0) begin : g_base
      csa_rca #(.W(GW)) u_rca (
        .a  (a_in[LSB +: GW]),
        .b  (b_in[LSB +: GW]),
        .ci (grp_carry[0]),
        .s  (sum_out[LSB +: GW]),
        .co (grp_carry[1])
      );
    end else begin : g_upper
      csa_group #(.W(GW)) u_grp (
        .a   (a_in[LSB +: GW]),
        .b   (b_in[LSB +: GW]),
        .sel (grp_carry[g]),
        .s   (sum_out[LSB +: GW]),
        .co  (grp_carry[g+1])
      );
    end
  end

  assign carry_out = grp_carry[NGRP];

  always_comb begin
    if (!$isunknown({a_in, b_in, carry_in})) begin
      a_r1_full_sum: assert ({carry_out, sum_out} ==
                             ((WIDTH+1)'(a_in) + (WIDTH+1)'(b_in) + (WIDTH+1)'(carry_in)))
        else $error("R1 full sum wrong");
      if (NGRP > 1 && WIDTH >= 2) begin
        a_r7_base_carry: assert (grp_carry[1] ==
                                 3'(3'(a_in[1:0]) + 3'(b_in[1:0]) + 3'(carry_in)) >> 2)
          else $error("R7 base slice carry wrong");
      end
      for (int g = 1; g < NGRP; g++) begin
        a_r7_boundary_carry: assert (grp_carry[g] ==
                                     (a_in[grp_lsb(WIDTH, g)] ^ b_in[grp_lsb(WIDTH, g)] ^
                                      sum_out[grp_lsb(WIDTH, g)]))
          else $error("R7 carry into slice wrong");
      end
    end
  end

endmodule

// File: tb/test_sqrt_csel_adder.sv
`timescale 1ns/1ps
module test_sqrt_csel_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [127:0] opa, opb;
  logic         cin;
  logic [7:0]   a8, b8;
  logic         c8;

  logic [7:0]   s8;   logic co8;
  logic [15:0]  s16;  logic co16;
  logic [31:0]  s32;  logic co32;
  logic [63:0]  s64;  logic co64;
  logic [127:0] s128; logic co128;

  sqrt_csel_adder #(.WIDTH(8))  i_w8  (.a_in(a8), .b_in(b8), .carry_in(c8),
                                       .sum_out(s8), .carry_out(co8));
  sqrt_csel_adder #(.WIDTH(16)) i_w16 (.a_in(opa[15:0]), .b_in(opb[15:0]), .carry_in(cin),
                                       .sum_out(s16), .carry_out(co16));
  sqrt_csel_adder #(.WIDTH(32)) i_w32 (.a_in(opa[31:0]), .b_in(opb[31:0]), .carry_in(cin),
                                       .sum_out(s32), .carry_out(co32));
  sqrt_csel_adder #(.WIDTH(64)) i_w64 (.a_in(opa[63:0]), .b_in(opb[63:0]), .carry_in(cin),
                                       .sum_out(s64), .carry_out(co64));
  sqrt_csel_adder i_sqrt_csel_adder (.a_in(opa), .b_in(opb), .carry_in(cin),
                                     .sum_out(s128), .carry_out(co128));

  function automatic logic [128:0] ref_add(input int w, input logic [127:0] a,
                                           input logic [127:0] b, input logic c);
    logic [128:0] m;
    logic [128:0] r;
    m = (129'(1) << w) - 129'(1);
    r = (129'(a) & m) + (129'(b) & m) + 129'(c);
    return r & ((m << 1) | 129'(1));
  endfunction

  function automatic logic [128:0] got_of(input int w);
    case (w)
      16:      return 129'({co16, s16});
      32:      return 129'({co32, s32});
      64:      return 129'({co64, s64});
      default: return {co128, s128};
    endcase
  endfunction

  task automatic cmp(input string req, input int w, input logic [128:0] got,
                     input logic [128:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s width=%0d actual=%h expected=%h", req, w, got, exp);
    end
  endtask

  // Apply opa/opb/cin and compare every wide instance
  task automatic apply_all(input string req, input logic [127:0] a,
                           input logic [127:0] b, input logic c);
    opa = a; opb = b; cin = c;
    #2;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = 16 << k;
      cmp(req, w, got_of(w), ref_add(w, a, b, c));
    end
  endtask

  logic [63:0] lfsr_st = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] step(input logic [63:0] v);
    logic [63:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [128:0] r0, r1;
    opa = '0; opb = '0; cin = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    #7;

    // R1: idle zero inputs give zero outputs
    apply_all("R1 zero", '0, '0, 1'b0);

    // R1 R6 R7: exhaustive 8-bit sweep (slices 2,2,3,1)
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          a8 = 8'(a); b8 = 8'(b); c8 = c[0];
          #1;
          cmp("R1 R6 R7 sweep8", 8, 129'({co8, s8}), 129'(a + b + c));
        end
      end
    end

    // R3: all-ones operands with both carry-in values
    apply_all("R3 ones cin0", '1, '1, 1'b0);
    apply_all("R3 ones cin1", '1, '1, 1'b1);
    opa = '1; opb = '1; cin = 1'b1; #2;
    cmp("R3 ones cin1 128", 128, {co128, s128}, {1'b1, {128{1'b1}}});

    // R4 R7: carries rippling out of every low run of ones
    for (int k = 0; k <= 128; k++) begin
      logic [127:0] run;
      run = (k == 128) ? '1 : ((128'(1) << k) - 128'(1));
      apply_all("R4 R7 ripple", run, '0, 1'b1);
      apply_all("R4 R7 ripple b", run, 128'(1), 1'b0);
    end
    opa = '1; opb = '0; cin = 1'b1; #2;
    cmp("R4 top ripple 128", 128, {co128, s128}, {1'b1, 128'(0)});

    // R1 R2 R5 R6: pseudo-random operands, each with both carry-in values
    for (int n = 0; n < 3000; n++) begin
      logic [127:0] ra, rb;
      lfsr_st = step(lfsr_st); ra[63:0]   = lfsr_st;
      lfsr_st = step(lfsr_st); ra[127:64] = lfsr_st;
      lfsr_st = step(lfsr_st); rb[63:0]   = lfsr_st;
      lfsr_st = step(lfsr_st); rb[127:64] = lfsr_st;
      if (n % 4 == 1) rb = ~ra;
      apply_all("R1 R5 R6 random", ra, rb, 1'b0);
      r0 = {co128, s128};
      apply_all("R1 R5 R6 random", ra, rb, 1'b1);
      r1 = {co128, s128};
      cmp("R2 cin step", 128, r1, r0 + 129'(1));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule